// File: doc/BRIEF.md
# Host Serial Write/Read Sequencer

This block is the host side of a four-wire serial port on a metering slave. It drives an active-low select (`cs_n`), a direction/latch strobe (`syn`), a serial clock (`sclk`) and the data line (`sda_out`/`sda_oe`). It also samples the slave's data (`sda_in`). Every line is emulated bit by bit from the system clock, so one block handles both a slow command write and a fast record read.

A write transaction drains command bytes from a show-ahead FIFO interface (`cmd_valid`, `cmd_data`, `cmd_pop`) and sends each byte MSB first. A read transaction first pulses `syn` to latch the slave's results. It can then clock a 0xFF precharge byte. Finally it clocks in `rec_count` 32-bit records, each presented with a one-cycle `rec_valid`. Every hold interval is a parameter in system-clock cycles, and `busy` covers the whole transaction.

Top module: `hsq_host`

## Requirements
- R1: After reset, `cs_n`, `syn` and `sclk` are high, and `busy`, `rec_valid` and `cmd_pop` are low.
- R2: A write (`op_read`=0 at `start`) first lowers `cs_n` while `syn` is still high. It then lowers `syn` after `GAP_CYC` cycles. `syn` never falls while `cs_n` is high during a write.
- R3: Each written bit drives `sclk` low for `WR_HALF_CYC` cycles and then high for at least `WR_HALF_CYC` cycles. `sda_out` (with `sda_oe`=1) holds the bit from the start of the low phase through the rising edge. Byte bit 7 is sent first.
- R4: A write sends every byte present in the FIFO, including bytes that arrive before the previous byte ends. `cmd_pop` pulses once, for one cycle, after the eighth bit of each byte.
- R5: A transaction ends by raising `syn` first and `cs_n` after it. `cs_n` never rises while `syn` is low.
- R6: A read (`op_read`=1) lowers `syn` for exactly `LATCH_CYC` cycles while `cs_n` is high, before anything else.
- R7: With `precharge_en`=1, `cs_n` falls while `syn` is still low. Eight `sclk` pulses are then sent with `sda_out`=1 and `sda_oe`=1. `syn` returns high before any record bit is sampled.
- R8: A read returns `rec_count` records of 32 bits, MSB first. Each bit is the value of `sda_in` at the falling `sclk` edge. Each record comes with a one-cycle `rec_valid`, and `rec_data` is valid in that cycle.
- R9: `start` is ignored while `busy` is high. No extra transaction follows and no FIFO byte is consumed.
- R10: `busy` falls only in a cycle where `cs_n`, `syn` and `sclk` are all high.
- R11: During the precharge and record phases, each `sclk` low phase lasts `RD_HALF_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Transaction request strobe |
| op_read | input | 1 | 1 = read transaction, 0 = write transaction |
| precharge_en | input | 1 | Read: send a 0xFF precharge byte first |
| rec_count | input | RCW | Number of 32-bit records to read |
| cmd_valid | input | 1 | FIFO holds a command byte |
| cmd_data | input | 8 | Command byte at the FIFO head |
| cmd_pop | output | 1 | Remove the head byte from the FIFO |
| sda_in | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Port select, active low |
| syn | output | 1 | Direction / latch strobe (low = write or latch) |
| sclk | output | 1 | Serial clock, idle high |
| sda_out | output | 1 | Serial data to the slave |
| sda_oe | output | 1 | Host drives the data line |
| rec_data | output | WORD_W | Received record |
| rec_valid | output | 1 | `rec_data` holds a complete record |
| busy | output | 1 | Transaction in progress |

## Verification
The write path is tried with command bytes of mixed bit patterns (0xAF, 0x3C, 0x81, 0x00). These expose a bit-order reversal, a stuck data line and a missing or duplicated byte. The read path is tried with precharge on and two records, and with precharge off and three records. The record words mix alternating, all-one, single-MSB and single-LSB patterns, which separates an off-by-one sampling edge from a wrong word boundary. The two read variants also distinguish the two select/strobe orderings. A start pulse issued during a read, with a byte waiting in the FIFO, shows whether a busy request is truly dropped or leaks into a later write.

// File: rtl/hsq_pkg.sv
// Package: state encoding shared by the sequencer and its helpers.
// Assumes 16 states fit a 4-bit encoding.
package hsq_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_W_CS, ST_W_SYN, ST_W_NXT, ST_W_LO, ST_W_HI, ST_W_SYNH, ST_END,
        ST_R_LAT, ST_R_SYNH, ST_R_PCS, ST_P_LO, ST_P_HI, ST_RD_GO, ST_R_LO, ST_R_HI
    } hsq_state_e;
endpackage

// File: rtl/hsq_timer.sv
// Interval timer: loads a cycle count and counts down; done while the count is zero.
// Assumes load is asserted in the cycle the owner enters a new phase.
module hsq_timer #(
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          done
);
    logic [TW-1:0] cnt;

    // Count down from the loaded value, saturating at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R3/R11: a phase lasts its programmed length, one cycle per count
    a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/hsq_rxword.sv
// Record assembler: shifts sampled bits in MSB first and flags each full word.
// Assumes shift strobes are at least two cycles apart.
module hsq_rxword #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word,
    output logic              valid
);
    localparam int CW = $clog2(WORD_W);
    logic [CW-1:0] cnt;

    // Accumulate bits and pulse valid when the last bit of a word lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            word  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (clr) begin
                cnt <= '0;
            end else if (shift) begin
                word <= {word[WORD_W-2:0], bit_i};
                if (cnt == CW'(WORD_W - 1)) begin
                    cnt   <= '0;
                    valid <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R8: a record strobe lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
endmodule

// File: rtl/hsq_host.sv
// Host sequencer for a four-wire select/strobe/clock/data port.
// Write: select, strobe low, bytes MSB first, strobe high, deselect.
// Read: latch pulse on the strobe, optional 0xFF precharge, then 32-bit records.
// Assumes all *_CYC parameters are >= 1 and the command FIFO is show-ahead.
module hsq_host
    import hsq_pkg::*;
#(
    parameter int GAP_CYC     = 4,
    parameter int LATCH_CYC   = 120,
    parameter int WR_HALF_CYC = 600,
    parameter int RD_HALF_CYC = 2,
    parameter int RCW         = 8,
    parameter int WORD_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_read,
    input  logic              precharge_en,
    input  logic [RCW-1:0]    rec_count,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_data,
    output logic              cmd_pop,
    input  logic              sda_in,
    output logic              cs_n,
    output logic              syn,
    output logic              sclk,
    output logic              sda_out,
    output logic              sda_oe,
    output logic [WORD_W-1:0] rec_data,
    output logic              rec_valid,
    output logic              busy
);
    localparam int M1   = (GAP_CYC > LATCH_CYC) ? GAP_CYC : LATCH_CYC;
    localparam int M2   = (WR_HALF_CYC > RD_HALF_CYC) ? WR_HALF_CYC : RD_HALF_CYC;
    localparam int MAXD = (M1 > M2) ? M1 : M2;
    localparam int TW   = $clog2(MAXD + 1);
    localparam int BW   = $clog2(WORD_W);

    hsq_state_e     state, state_d;
    logic           is_rd, do_pre;
    logic [RCW-1:0] wleft;
    logic [BW-1:0]  bitn;
    logic [7:0]     wsh;
    logic           tdone, tload;
    logic [TW-1:0]  tval;
    logic           ld_byte, shift_byte, bit_clr, bit_inc, wdec, sample, accept;

    // Phase length for the state being entered, minus one.
    function automatic logic [TW-1:0] dur_of(hsq_state_e s);
        case (s)
            ST_W_LO, ST_W_HI:                  return TW'(WR_HALF_CYC - 1);
            ST_P_LO, ST_P_HI, ST_R_LO, ST_R_HI: return TW'(RD_HALF_CYC - 1);
            ST_R_LAT:                          return TW'(LATCH_CYC - 1);
            ST_W_NXT:                          return '0;
            default:                           return TW'(GAP_CYC - 1);
        endcase
    endfunction

    assign accept = (state == ST_IDLE) && start;

    // Next-state and per-transition control strobes.
    always_comb begin
        state_d = state;
        ld_byte = 1'b0; shift_byte = 1'b0; bit_clr = 1'b0; bit_inc = 1'b0;
        wdec = 1'b0; sample = 1'b0; cmd_pop = 1'b0;
        if (accept) begin
            state_d = op_read ? ST_R_LAT : ST_W_CS;
        end else if (tdone) begin
            case (state)
                ST_W_CS:   state_d = ST_W_SYN;
                ST_W_SYN:  state_d = ST_W_NXT;
                ST_W_NXT:  if (cmd_valid) begin
                               ld_byte = 1'b1; bit_clr = 1'b1; state_d = ST_W_LO;
                           end else begin
                               state_d = ST_W_SYNH;
                           end
                ST_W_LO:   state_d = ST_W_HI;
                ST_W_HI:   if (bitn == BW'(7)) begin
                               cmd_pop = 1'b1; state_d = ST_W_NXT;
                           end else begin
                               shift_byte = 1'b1; bit_inc = 1'b1; state_d = ST_W_LO;
                           end
                ST_W_SYNH: state_d = ST_END;
                ST_END:    state_d = ST_IDLE;
                ST_R_LAT:  state_d = do_pre ? ST_R_PCS : ST_R_SYNH;
                ST_R_SYNH: state_d = ST_RD_GO;
                ST_R_PCS:  begin bit_clr = 1'b1; state_d = ST_P_LO; end
                ST_P_LO:   state_d = ST_P_HI;
                ST_P_HI:   if (bitn == BW'(7)) state_d = ST_RD_GO;
                           else begin bit_inc = 1'b1; state_d = ST_P_LO; end
                ST_RD_GO:  if (wleft == '0) state_d = ST_END;
                           else begin bit_clr = 1'b1; sample = 1'b1; state_d = ST_R_LO; end
                ST_R_LO:   state_d = ST_R_HI;
                ST_R_HI:   if (bitn == BW'(WORD_W - 1)) begin
                               if (wleft == RCW'(1)) state_d = ST_END;
                               else begin
                                   wdec = 1'b1; bit_clr = 1'b1; sample = 1'b1;
                                   state_d = ST_R_LO;
                               end
                           end else begin
                               bit_inc = 1'b1; sample = 1'b1; state_d = ST_R_LO;
                           end
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    assign tload = (state_d != state);
    assign tval  = dur_of(state_d);

    hsq_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tload), .val(tval), .done(tdone)
    );

    // State, transaction options, bit/word counters and the write shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            is_rd  <= 1'b0;
            do_pre <= 1'b0;
            wleft  <= '0;
            bitn   <= '0;
            wsh    <= '0;
        end else begin
            state <= state_d;
            if (accept) begin
                is_rd  <= op_read;
                do_pre <= precharge_en;
                wleft  <= rec_count;
            end
            if (wdec)           wleft <= wleft - 1'b1;
            if (bit_clr)        bitn  <= '0;
            else if (bit_inc)   bitn  <= bitn + 1'b1;
            if (ld_byte)        wsh   <= cmd_data;
            else if (shift_byte) wsh  <= {wsh[6:0], 1'b0};
        end
    end

    hsq_rxword #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(accept), .shift(sample), .bit_i(sda_in),
        .word(rec_data), .valid(rec_valid)
    );

    // Port levels decoded from the registered state.
    always_comb begin
        cs_n    = 1'b1;
        syn     = 1'b1;
        sclk    = 1'b1;
        sda_oe  = 1'b0;
        sda_out = 1'b1;
        case (state)
            ST_W_CS, ST_W_SYNH, ST_RD_GO, ST_R_HI: cs_n = 1'b0;
            ST_W_SYN, ST_W_NXT, ST_W_HI: begin
                cs_n = 1'b0; syn = 1'b0; sda_oe = 1'b1; sda_out = wsh[7];
            end
            ST_W_LO: begin
                cs_n = 1'b0; syn = 1'b0; sclk = 1'b0; sda_oe = 1'b1; sda_out = wsh[7];
            end
            ST_R_LAT: syn = 1'b0;
            ST_R_PCS, ST_P_HI: begin cs_n = 1'b0; syn = 1'b0; sda_oe = 1'b1; end
            ST_P_LO:  begin cs_n = 1'b0; syn = 1'b0; sclk = 1'b0; sda_oe = 1'b1; end
            ST_R_LO:  begin cs_n = 1'b0; sclk = 1'b0; end
            default:  ;
        endcase
    end

    assign busy = (state != ST_IDLE);

    // R2: in a write, the strobe falls only after the select is low
    a_r2_select_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(syn) && !is_rd) |-> !cs_n);
    // R6: in a read, the latch pulse starts while the select is still high
    a_r6_latch_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(syn) && is_rd) |-> cs_n);
    // R5: the select never rises while the strobe is low
    a_r5_strobe_before_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> syn);
    // R10: when not busy, all three control lines sit at their high level
    a_r10_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && syn && sclk));
    // R7: precharge clock pulses carry a driven one
    a_r7_precharge_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && !cs_n && !syn && !sclk) |-> (sda_oe && sda_out));
    // R3: the clock is never low while the port is deselected
    a_r3_clock_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);
endmodule

// File: tb/hsq_host_test.sv
module hsq_host_test;
    localparam int GAP = 8, LAT = 260, WRH = 40, RDH = 3;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        start = 1'b0, op_read = 1'b0, precharge_en = 1'b0;
    logic [7:0]  rec_count = '0;
    logic        cmd_valid, cmd_pop, sda_in, cs_n, syn, sclk, sda_out, sda_oe;
    logic [7:0]  cmd_data;
    logic [31:0] rec_data;
    logic        rec_valid, busy;

    int checks = 0, errors = 0;
    logic [7:0]  fmem [0:15];
    int          fwr = 0, frd = 0, pops = 0, cs_falls = 0;
    logic [7:0]  exp_bytes [$];
    logic [31:0] exp_recs [$];
    logic [31:0] txq [$];
    logic [31:0] cur = '0;
    int          spos = 0, capn = 0, lowrun = 0, latrun = 0, exp_half = WRH;
    logic [7:0]  cap = '0;
    logic        exp_syn_csfall = 1'b1;
    logic        p_cs = 1'b1, p_syn = 1'b1, p_sclk = 1'b1, p_busy = 1'b0;

    always #2 clk = ~clk;

    assign cmd_valid = (fwr != frd);
    assign cmd_data  = fmem[frd % 16];
    assign sda_in    = cur[31 - spos];

    hsq_host #(.GAP_CYC(GAP), .LATCH_CYC(LAT), .WR_HALF_CYC(WRH), .RD_HALF_CYC(RDH))
    uut (.*);

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // FIFO pop side
    always @(posedge clk) if (cmd_pop) begin frd <= frd + 1; pops <= pops + 1; end

    // Monitor + slave model, evaluated away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_cs && !cs_n) begin
                cs_falls++;
                check(syn == exp_syn_csfall, "R2/R7 strobe level at select fall", syn, exp_syn_csfall);
            end
            if (!p_cs && cs_n) check(syn == 1'b1, "R5 strobe high at select rise", syn, 1);
            if (!cs_n && !sclk) lowrun++;
            else if (lowrun > 0) begin
                check(lowrun == exp_half, "R3/R11 clock low phase", lowrun, exp_half);
                lowrun = 0;
            end
            if (cs_n && !syn) latrun++;
            else if (latrun > 0) begin
                check(latrun == LAT, "R6 latch pulse length", latrun, LAT);
                latrun = 0;
            end
            if (!p_sclk && sclk && !cs_n && !syn && sda_oe) begin
                cap = {cap[6:0], sda_out};
                capn++;
                if (capn == 8) begin
                    capn = 0;
                    if (exp_bytes.size() == 0) check(0, "R4 unexpected byte", cap, 0);
                    else begin
                        logic [7:0] e;
                        e = exp_bytes.pop_front();
                        check(cap == e, "R3/R4/R7 byte on the line", cap, e);
                    end
                end
            end
            if (rec_valid) begin
                check(syn && !cs_n, "R7 strobe high during records", syn, 1);
                if (exp_recs.size() == 0) check(0, "R8 unexpected record", rec_data, 0);
                else begin
                    logic [31:0] e;
                    e = exp_recs.pop_front();
                    check(rec_data == e, "R8 record value", rec_data, e);
                end
            end
            if (p_busy && !busy)
                check(cs_n && syn && sclk, "R10 levels at busy fall", {cs_n, syn, sclk}, 3'b111);
            // slave transmitter: advance on rising clock in read mode
            if (cs_n || !syn) spos = 0;
            else if (!p_sclk && sclk) begin
                spos++;
                if (spos == 32) begin
                    spos = 0;
                    if (txq.size() > 0) cur = txq.pop_front();
                end
            end
        end
        p_cs = cs_n; p_syn = syn; p_sclk = sclk; p_busy = busy;
    end

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy && n < 30000) begin @(negedge clk); n++; end
        if (busy) check(0, "R10 watchdog expired", 1, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic push_cmd(input logic [7:0] b);
        fmem[fwr % 16] = b;
        fwr++;
        exp_bytes.push_back(b);
    endtask

    task automatic pulse_start(input logic rd, input logic pre, input int n);
        op_read = rd; precharge_en = pre; rec_count = 8'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_read(input logic pre, input int n, input logic [31:0] w [$]);
        if (pre) exp_bytes.push_back(8'hFF);
        exp_syn_csfall = !pre;
        exp_half = RDH;
        foreach (w[i]) exp_recs.push_back(w[i]);
        txq = w;
        cur = txq.pop_front();
        pulse_start(1'b1, pre, n);
    endtask

    initial begin
        int f0, p0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cs_n && syn && sclk, "R1 idle levels", {cs_n, syn, sclk}, 3'b111);
        check(!busy && !rec_valid && !cmd_pop, "R1 quiet outputs", {busy, rec_valid, cmd_pop}, 0);

        // Write of two bytes; R4 pop count
        exp_syn_csfall = 1'b1; exp_half = WRH;
        push_cmd(8'hAF); push_cmd(8'h3C);
        pulse_start(1'b0, 1'b0, 0);
        wait_idle();
        check(pops == 2, "R4 pop count after two bytes", pops, 2);
        check(exp_bytes.size() == 0, "R4 all bytes sent", exp_bytes.size(), 0);

        // Read with precharge, two records
        do_read(1'b1, 2, '{32'hA5C3_0F81, 32'h8000_0000});
        wait_idle();
        check(exp_recs.size() == 0, "R8 both records seen", exp_recs.size(), 0);
        check(exp_bytes.size() == 0, "R7 precharge byte seen", exp_bytes.size(), 0);

        // Read without precharge, three records; a write request mid-read must be ignored
        f0 = cs_falls; p0 = pops;
        do_read(1'b0, 3, '{32'h1234_5678, 32'hFFFF_0001, 32'h0000_0001});
        repeat (60) @(negedge clk);
        fmem[fwr % 16] = 8'h81; fwr++;
        pulse_start(1'b0, 1'b0, 0);
        wait_idle();
        check(cs_falls == f0 + 1, "R9 no extra transaction", cs_falls, f0 + 1);
        check(pops == p0 && cmd_valid, "R9 FIFO untouched", pops, p0);
        check(exp_recs.size() == 0, "R8 three records seen", exp_recs.size(), 0);

        // Write draining the leftover byte plus one more
        exp_bytes.push_back(8'h81);
        exp_syn_csfall = 1'b1; exp_half = WRH;
        push_cmd(8'h00);
        p0 = pops;
        pulse_start(1'b0, 1'b0, 0);
        wait_idle();
        check(pops == p0 + 2, "R4 leftover and new byte popped", pops, p0 + 2);
        check(exp_bytes.size() == 0 && !cmd_valid, "R4 FIFO drained", exp_bytes.size(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule